// File: doc/BRIEF.md
# Voltage Regulator Soft-Start Sequencer

This synchronous controller takes a multiphase voltage regulator out of shutdown and ramps its reference DAC code in two stages. It watches three digitized qualifiers: bias power-on-reset and two enable comparators. While any of them is low, the PWM outputs are held high-impedance and the DAC code is held at zero. Once all three are high, the block waits a fixed delay. It then steps the code up to a fixed boot code, one step per tick of an external soft-start oscillator.

At the boot code the block holds for a fixed number of cycles and until the VID bus has been stable long enough to trust. It then samples VID. A reserved OFF code latches the block off until a qualifier is removed and reapplied. Any other code is turned into a target code, and a second ramp steps up or down to that target and stops exactly on it. Once start-up is finished, the ready flag follows the external power-good window flag.

Top module: `vr_softstart_seq`

## Requirements
- R1: After reset, and whenever any qualifier is low, `pwm_oe` is 0, `dac_code` is 0, `vr_ready` is 0 and `latched_off` is 0.
- R2: The block leaves shutdown only when `bias_ok`, `en_a_ok` and `en_b_ok` are all 1. With any one of them held at 0, `pwm_oe` stays 0.
- R3: Take the first rising edge at which all qualifiers are high as edge 1. `pwm_oe` is 1 after edge 1, and `dac_code` stays 0 through edge TD1_CYC+1.
- R4: During a ramp, `dac_code` changes by exactly one LSB, and only at an edge where `ss_tick` is 1. With `ss_tick` held at 0 the code does not move.
- R5: The first ramp ends at BOOT_CODE. With `ss_tick` held at 1, the code equals BOOT_CODE after edge TD1_CYC+1+BOOT_CODE.
- R6: The code stays at BOOT_CODE for at least TD3_CYC edges after the ramp state ends. It also stays there for as long as VID has not held one value for VID_STABLE_CYC consecutive edges.
- R7: A sampled VID value v that is not an OFF code gives the target max(v-OFFSET_CODE, 0). The second ramp runs up or down to the target and stops on it without overshoot. After the sample, changes on VID are ignored.
- R8: A sampled VID equal to OFF_CODE_A (default 8'h00) or OFF_CODE_B (default 8'hFF) sets `latched_off` to 1, with `pwm_oe` 0 and `dac_code` 0. This state lasts while the qualifiers stay high, whatever VID does.
- R9: Removing any qualifier and then reapplying it clears the latch-off and runs a new soft-start.
- R10: `vr_ready` is 1 only when the second ramp has reached its target and `pg_window` is 1.
- R11: If any qualifier drops at any point in the sequence, then at the next edge `pwm_oe` is 0, `dac_code` is 0 and `vr_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bias_ok | input | 1 | Bias power-on-reset satisfied |
| en_a_ok | input | 1 | First enable comparator above threshold |
| en_b_ok | input | 1 | Second enable comparator above threshold |
| vid | input | VID_W | Voltage identification code |
| ss_tick | input | 1 | Soft-start oscillator tick, one ramp step |
| pg_window | input | 1 | Output voltage inside the regulation window |
| dac_code | output | CODE_W | Reference DAC code |
| pwm_oe | output | 1 | PWM output enable (0 = high-impedance) |
| vr_ready | output | 1 | Regulator ready |
| latched_off | output | 1 | Shut down by OFF code, waiting for requalification |

## Verification
The bench builds the block with TD1_CYC=20, TD3_CYC=8, VID_STABLE_CYC=4, BOOT_CODE=16 and OFFSET_CODE=2. With these values a full start-up takes only a few dozen cycles, so each run can check exact edge positions for the delay, the boot arrival and the first step of the second ramp. The same values allow targets above, below and equal to the boot code, a target clipped to zero, both OFF codes, and a VID bus that never settles during the hold.

// File: rtl/vrss_pkg.sv
package vrss_pkg;

    typedef enum logic [2:0] {
        ST_SHUT      = 3'd0,
        ST_DELAY     = 3'd1,
        ST_RAMP_BOOT = 3'd2,
        ST_HOLD      = 3'd3,
        ST_RAMP_VID  = 3'd4,
        ST_RUN       = 3'd5,
        ST_OFF       = 3'd6
    } vrss_state_e;

endpackage

// File: rtl/vrss_vid_filter.sv
module vrss_vid_filter #(
    parameter int VID_W          = 8,
    parameter int VID_STABLE_CYC = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VID_W-1:0] vid,
    output logic [VID_W-1:0] vid_held,
    output logic             vid_ok
);
    localparam int STB_W = $clog2(VID_STABLE_CYC + 1);

    logic [VID_W-1:0] prev_d, prev_q;
    logic [STB_W-1:0] cnt_d,  cnt_q;

    always_comb begin
        prev_d = vid;
        cnt_d  = cnt_q;
        if (vid != prev_q) begin
            cnt_d = '0;
        end else if (cnt_q != STB_W'(VID_STABLE_CYC)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            cnt_q  <= '0;
        end else begin
            prev_q <= prev_d;
            cnt_q  <= cnt_d;
        end
    end

    assign vid_held = prev_q;
    assign vid_ok   = (cnt_q == STB_W'(VID_STABLE_CYC)) && (vid == prev_q);

endmodule

// File: rtl/vrss_stepper.sv
module vrss_stepper #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] goal,
    input  logic              tick,
    output logic [CODE_W-1:0] next_code,
    output logic              at_goal
);
    always_comb begin
        next_code = code;
        if (tick) begin
            if (code < goal) begin
                next_code = code + 1'b1;
            end else if (code > goal) begin
                next_code = code - 1'b1;
            end
        end
    end

    assign at_goal = (code == goal);

endmodule

// File: rtl/vr_softstart_seq.sv
module vr_softstart_seq
    import vrss_pkg::*;
#(
    parameter int               CODE_W         = 8,
    parameter int               VID_W          = 8,
    parameter int               TD1_CYC        = 136000,
    parameter int               TD3_CYC        = 8500,
    parameter int               VID_STABLE_CYC = 50,
    parameter int               BOOT_CODE      = 176,
    parameter int               OFFSET_CODE    = 0,
    parameter logic [VID_W-1:0] OFF_CODE_A     = '0,
    parameter logic [VID_W-1:0] OFF_CODE_B     = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bias_ok,
    input  logic              en_a_ok,
    input  logic              en_b_ok,
    input  logic [VID_W-1:0]  vid,
    input  logic              ss_tick,
    input  logic              pg_window,
    output logic [CODE_W-1:0] dac_code,
    output logic              pwm_oe,
    output logic              vr_ready,
    output logic              latched_off
);
    localparam int CNT_MAX = (TD1_CYC > TD3_CYC) ? TD1_CYC : TD3_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        vrss_state_e       st;
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] code;
        logic [CODE_W-1:0] target;
    } seq_s;

    function automatic logic [CODE_W-1:0] vid_to_code(input logic [VID_W-1:0] v);
        if (int'(v) > OFFSET_CODE) begin
            return CODE_W'(int'(v) - OFFSET_CODE);
        end
        return '0;
    endfunction

    function automatic logic is_off_code(input logic [VID_W-1:0] v);
        return (v == OFF_CODE_A) || (v == OFF_CODE_B);
    endfunction

    seq_s              s_d, s_q;
    logic              qual_ok;
    logic [VID_W-1:0]  vid_held;
    logic              vid_ok;
    logic [CODE_W-1:0] goal, step_code;
    logic              at_goal;

    assign qual_ok = bias_ok && en_a_ok && en_b_ok;
    assign goal    = (s_q.st == ST_RAMP_VID) ? s_q.target : CODE_W'(BOOT_CODE);

    vrss_vid_filter #(
        .VID_W         (VID_W),
        .VID_STABLE_CYC(VID_STABLE_CYC)
    ) u_vid (
        .clk     (clk),
        .rst_n   (rst_n),
        .vid     (vid),
        .vid_held(vid_held),
        .vid_ok  (vid_ok)
    );

    vrss_stepper #(
        .CODE_W(CODE_W)
    ) u_step (
        .code     (s_q.code),
        .goal     (goal),
        .tick     (ss_tick),
        .next_code(step_code),
        .at_goal  (at_goal)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_SHUT: begin
                s_d.code = '0;
                s_d.cnt  = '0;
                if (qual_ok) s_d.st = ST_DELAY;
            end
            ST_DELAY: begin
                if (s_q.cnt == CNT_W'(TD1_CYC - 1)) begin
                    s_d.st  = ST_RAMP_BOOT;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_RAMP_BOOT: begin
                if (at_goal) begin
                    s_d.st  = ST_HOLD;
                    s_d.cnt = '0;
                end else begin
                    s_d.code = step_code;
                end
            end
            ST_HOLD: begin
                if (s_q.cnt != CNT_W'(TD3_CYC - 1)) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end else if (vid_ok) begin
                    if (is_off_code(vid_held)) begin
                        s_d.st   = ST_OFF;
                        s_d.code = '0;
                    end else begin
                        s_d.st     = ST_RAMP_VID;
                        s_d.target = vid_to_code(vid_held);
                    end
                end
            end
            ST_RAMP_VID: begin
                if (at_goal) s_d.st = ST_RUN;
                else         s_d.code = step_code;
            end
            ST_RUN, ST_OFF: begin
                s_d = s_q;
            end
            default: begin
                s_d.st = ST_SHUT;
            end
        endcase
        if (!qual_ok) begin
            s_d.st   = ST_SHUT;
            s_d.code = '0;
            s_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st     <= ST_SHUT;
            s_q.cnt    <= '0;
            s_q.code   <= '0;
            s_q.target <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dac_code    = s_q.code;
    assign pwm_oe      = (s_q.st != ST_SHUT) && (s_q.st != ST_OFF);
    assign vr_ready    = (s_q.st == ST_RUN) && pg_window;
    assign latched_off = (s_q.st == ST_OFF);

endmodule

// File: rtl/vrss_checker.sv
module vrss_checker #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bias_ok,
    input logic              en_a_ok,
    input logic              en_b_ok,
    input logic              ss_tick,
    input logic              pg_window,
    input logic [CODE_W-1:0] dac_code,
    input logic              pwm_oe,
    input logic              vr_ready,
    input logic              latched_off
);
    AST_SHUT_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bias_ok && en_a_ok && en_b_ok) |=> (!pwm_oe && dac_code == '0 && !vr_ready)); // R11

    AST_RELEASE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_oe) |-> $past(bias_ok && en_a_ok && en_b_ok)); // R2

    AST_ONE_STEP_PER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_oe && $past(pwm_oe) && dac_code != $past(dac_code)) |->
        ($past(ss_tick) && (dac_code == $past(dac_code) + CODE_W'(1) ||
                            dac_code == $past(dac_code) - CODE_W'(1)))); // R4

    AST_LATCH_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        latched_off |-> (!pwm_oe && dac_code == '0)); // R8

    AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        vr_ready |-> (pg_window && pwm_oe && !latched_off)); // R10

endmodule

bind vr_softstart_seq vrss_checker #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bias_ok    (bias_ok),
    .en_a_ok    (en_a_ok),
    .en_b_ok    (en_b_ok),
    .ss_tick    (ss_tick),
    .pg_window  (pg_window),
    .dac_code   (dac_code),
    .pwm_oe     (pwm_oe),
    .vr_ready   (vr_ready),
    .latched_off(latched_off)
);

// File: tb/sim_vr_softstart_seq.sv
module sim_vr_softstart_seq;
    localparam int TD1  = 20;
    localparam int TD3  = 8;
    localparam int VSTB = 4;
    localparam int BOOT = 16;
    localparam int OFS  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bias_ok = 1'b0, en_a_ok = 1'b0, en_b_ok = 1'b0;
    logic [7:0] vid = 8'd40;
    logic       ss_tick = 1'b0;
    logic       pg_window = 1'b1;
    logic [7:0] dac_code;
    logic       pwm_oe, vr_ready, latched_off;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vr_softstart_seq #(
        .CODE_W(8), .VID_W(8), .TD1_CYC(TD1), .TD3_CYC(TD3),
        .VID_STABLE_CYC(VSTB), .BOOT_CODE(BOOT), .OFFSET_CODE(OFS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .en_a_ok(en_a_ok),
        .en_b_ok(en_b_ok), .vid(vid), .ss_tick(ss_tick), .pg_window(pg_window),
        .dac_code(dac_code), .pwm_oe(pwm_oe), .vr_ready(vr_ready),
        .latched_off(latched_off)
    );

    // vid, expected code, pg_window, expected ready, expected latched_off, expected pwm_oe
    localparam logic [19:0] VEC [6] = '{
        {8'd40,  8'd38, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'd10,  8'd8,  1'b1, 1'b1, 1'b0, 1'b1},
        {8'd18,  8'd16, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'd0,   8'd0,  1'b1, 1'b0, 1'b1, 1'b0},
        {8'd255, 8'd0,  1'b1, 1'b0, 1'b1, 1'b0},
        {8'd1,   8'd0,  1'b1, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quals(input logic b, input logic a, input logic e);
        bias_ok = b; en_a_ok = a; en_b_ok = e;
    endtask

    task automatic restart();
        quals(0, 0, 0);
        edges(2);
        quals(1, 1, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);
        // R1 reset state
        chk("R1 oe", int'(pwm_oe), 0);
        chk("R1 code", int'(dac_code), 0);
        chk("R1 ready", int'(vr_ready), 0);
        chk("R1 latched", int'(latched_off), 0);

        // R2 each qualifier missing blocks release
        quals(0, 1, 1); edges(10); chk("R2 bias missing", int'(pwm_oe), 0);
        quals(1, 0, 1); edges(10); chk("R2 en_a missing", int'(pwm_oe), 0);
        quals(1, 1, 0); edges(10); chk("R2 en_b missing", int'(pwm_oe), 0);

        // table walk: full start-ups
        ss_tick = 1'b1;
        for (int i = 0; i < 6; i++) begin
            vid       = VEC[i][19:12];
            pg_window = VEC[i][3];
            restart();
            edges(200);
            chk("R7 final code", int'(dac_code), int'(VEC[i][11:4]));
            chk("R10 ready", int'(vr_ready), int'(VEC[i][2]));
            chk("R8 latched", int'(latched_off), int'(VEC[i][1]));
            chk("R8 oe", int'(pwm_oe), int'(VEC[i][0]));
        end
        pg_window = 1'b1;

        // R3 R5 R6 exact timing with tick held high, target above boot
        vid = 8'd40;
        restart();
        edges(1);
        chk("R3 oe after release", int'(pwm_oe), 1);
        edges(TD1);
        chk("R3 code before ramp", int'(dac_code), 0);
        edges(1);
        chk("R4 first step", int'(dac_code), 1);
        edges(BOOT - 1);
        chk("R5 boot reached", int'(dac_code), BOOT);
        edges(TD3 + 1);
        chk("R6 hold at boot", int'(dac_code), BOOT);
        edges(1);
        chk("R7 second ramp starts", int'(dac_code), BOOT + 1);
        edges(100);
        vid = 8'd60;
        edges(10);
        chk("R7 vid ignored after sample", int'(dac_code), 38);

        // R4 no tick, no step; single pulses give single steps
        vid = 8'd40;
        ss_tick = 1'b0;
        restart();
        edges(TD1 + 30);
        chk("R4 no tick", int'(dac_code), 0);
        for (int k = 0; k < 5; k++) begin
            ss_tick = 1'b1; edges(1);
            ss_tick = 1'b0; edges(2);
        end
        chk("R4 five ticks", int'(dac_code), 5);

        // R11 loss of a qualifier mid-ramp
        quals(0, 1, 1);
        edges(1);
        chk("R11 code", int'(dac_code), 0);
        chk("R11 oe", int'(pwm_oe), 0);

        // R6 unsettled VID keeps the hold at boot
        ss_tick = 1'b1;
        vid = 8'd40;
        restart();
        edges(TD1 + 2 + BOOT);
        for (int k = 0; k < 30; k++) begin
            vid = (k % 2 == 0) ? 8'd41 : 8'd40;
            edges(1);
        end
        chk("R6 unstable vid holds", int'(dac_code), BOOT);
        vid = 8'd40;
        edges(100);
        chk("R6 settles then ramps", int'(dac_code), 38);
        chk("R10 ready after ramp", int'(vr_ready), 1);
        pg_window = 1'b0;
        edges(1);
        chk("R10 ready follows window", int'(vr_ready), 0);
        pg_window = 1'b1;
        // R11 loss while running
        quals(1, 1, 0);
        edges(1);
        chk("R11 ready drops", int'(vr_ready), 0);

        // R8 R9 latch-off persists, then requalification restarts
        vid = 8'hFF;
        restart();
        edges(200);
        chk("R8 latched", int'(latched_off), 1);
        vid = 8'd30;
        edges(60);
        chk("R8 vid ignored while latched", int'(latched_off), 1);
        chk("R8 code while latched", int'(dac_code), 0);
        quals(1, 0, 1);
        edges(1);
        chk("R9 latch cleared", int'(latched_off), 0);
        quals(1, 1, 1);
        edges(200);
        chk("R9 restart code", int'(dac_code), 28);
        chk("R9 restart ready", int'(vr_ready), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule